// File: doc/BRIEF.md
# Sixteen-Channel Trigger Condition Matcher

This block evaluates a single-stage trigger condition over a 16-bit logic sample stream. Four per-channel masks set it up. One mask says which channels take part. One says which of those are enabled. One picks level or edge matching. One picks the polarity: high or falling when set, low or rising when clear. Bit i of each mask always refers to channel i. A channel is used only when both its take-part bit and its enable bit are set. Each accepted sample is compared with the previous accepted sample. The block raises a one-cycle hit pulse when every used channel meets its condition in the same sample.

The matcher is armed by a level input. It is driven by a four-state machine:

- **IDLE:** the machine sits here while `arm` is low, and returns here from any state in the cycle after `arm` falls.
- **FIRST:** raising `arm` moves IDLE to FIRST. In this state there is no previous sample, so no edge can match yet.
- **HUNT:** a valid sample that does not fire moves FIRST to HUNT, where edge matching becomes possible.
- **DONE:** a valid sample that fires moves FIRST or HUNT to DONE. DONE holds until `arm` drops, so each arming yields at most one pulse.

If no channel is used, the condition is empty. The first valid sample after arming then fires at once, so capture need not wait. The masks carry only the low 16 bits of the configuration words; the upper bits are never routed to the block.

Top module: `trig_matcher`

## Requirements
- R1: After reset `hit` is low and the machine is in IDLE.
- R2: Channel i is used only when bit i of `cfg_involve` and bit i of `cfg_enable` are both 1. A channel missing either bit never blocks or causes a hit.
- R3: A used channel with `cfg_level` bit 1 matches when its sample bit equals its `cfg_polarity` bit. Polarity 1 means high and 0 means low.
- R4: A used channel with `cfg_level` bit 0 matches on an edge against the previous accepted sample. Polarity 0 needs previous 0 and current 1 (rising). Polarity 1 needs previous 1 and current 0 (falling).
- R5: A hit requires every used channel to match in the same accepted sample.
- R6: The first accepted sample after arming cannot satisfy an edge channel.
- R7: When no channel is used, the first accepted sample after arming fires.
- R8: At most one hit per arming. `arm` must go low and then high again before another hit can occur.
- R9: A sample is accepted only when `smp_valid` is 1 and the machine is in FIRST or HUNT. Samples that are not accepted neither fire nor update the previous-sample history.
- R10: `hit` is high for exactly the one cycle after the clock edge that accepted the matching sample. A sample presented while `arm` is low never fires. Arming takes one cycle: the sample on the edge where `arm` first rises is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Level enable; rising starts a trigger search, low cancels it |
| cfg_involve | input | 16 | Per-channel take-part mask, bit i = channel i |
| cfg_enable | input | 16 | Per-channel enable mask, bit i = channel i |
| cfg_level | input | 16 | 1 = level match, 0 = edge match, per channel |
| cfg_polarity | input | 16 | 1 = high/falling, 0 = low/rising, per channel |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Logic sample, bit i = channel i |
| hit | output | 1 | One-cycle trigger pulse |

## Verification
The bench checks an edge channel whose very first sample already has the target value. A design that invents a previous value would fire one sample early. Invalid samples are placed between two valid ones so that the invalid data, if it were taken in, would mask a real rising edge. A design that updates its history on invalid strobes would then miss the trigger.

Repeated matching samples after a hit, followed by a disarm and rearm, expose a matcher that pulses more than once or never rearms. An empty condition, and a channel that is enabled but does not take part, catch designs that stall forever or let a half-configured channel gate the result.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_HUNT  = 2'd2,
        ST_DONE  = 2'd3
    } trg_state_e;
endpackage

// File: rtl/trig_hist.sv
module trig_hist #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [NCH-1:0] d,
    output logic [NCH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/trig_chan_eval.sv
module trig_chan_eval #(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] cur,
    input  logic [NCH-1:0] prev,
    input  logic           have_prev,
    input  logic [NCH-1:0] use_mask,
    input  logic [NCH-1:0] lvl_mask,
    input  logic [NCH-1:0] pol_mask,
    output logic           all_ok
);
    logic [NCH-1:0] ch_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic lvl_hit;
        logic edge_hit;
        // level: sample bit equals polarity; edge: previous at polarity, current at its inverse
        assign lvl_hit  = (cur[i] == pol_mask[i]);
        assign edge_hit = have_prev && (prev[i] == pol_mask[i]) && (cur[i] != pol_mask[i]);
        assign ch_ok[i] = !use_mask[i] || (lvl_mask[i] ? lvl_hit : edge_hit);
    end

    assign all_ok = &ch_ok;
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic [NCH-1:0] cfg_involve,
    input  logic [NCH-1:0] cfg_enable,
    input  logic [NCH-1:0] cfg_level,
    input  logic [NCH-1:0] cfg_polarity,
    input  logic           smp_valid,
    input  logic [NCH-1:0] smp_data,
    output logic           hit
);
    import trig_pkg::*;

    trg_state_e     state_q;
    trg_state_e     state_d;
    logic [NCH-1:0] use_mask;
    logic [NCH-1:0] prev_smp;
    logic           searching;
    logic           accept;
    logic           cond_ok;
    logic           fire;

    assign use_mask  = cfg_involve & cfg_enable;
    assign searching = (state_q == ST_FIRST) || (state_q == ST_HUNT);
    assign accept    = arm && smp_valid && searching;
    assign fire      = accept && cond_ok;

    trig_hist #(.NCH(NCH)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     (smp_data),
        .q     (prev_smp)
    );

    trig_chan_eval #(.NCH(NCH)) u_eval (
        .cur       (smp_data),
        .prev      (prev_smp),
        .have_prev (state_q == ST_HUNT),
        .use_mask  (use_mask),
        .lvl_mask  (cfg_level),
        .pol_mask  (cfg_polarity),
        .all_ok    (cond_ok)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!arm) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_FIRST;
                ST_FIRST: begin
                    if (fire)           state_d = ST_DONE;
                    else if (smp_valid) state_d = ST_HUNT;
                end
                ST_HUNT:  if (fire) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= fire;
        end
    end
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk #(
    parameter int NCH = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  arm,
    input logic                  smp_valid,
    input logic [NCH-1:0]        cfg_involve,
    input logic [NCH-1:0]        cfg_enable,
    input logic [NCH-1:0]        cfg_level,
    input logic                  hit,
    input trig_pkg::trg_state_e  state_q
);
    import trig_pkg::*;

    a_r10_hit_from_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(arm) && $past(smp_valid)));

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    a_r8_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> !hit);

    a_r7_empty_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && smp_valid && state_q == ST_FIRST && (cfg_involve & cfg_enable) == '0) |=> hit);

    a_r6_no_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && smp_valid && state_q == ST_FIRST
         && (cfg_involve & cfg_enable & ~cfg_level) != '0) |=> !hit);

    a_r9_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !hit);
endmodule

bind trig_matcher trig_matcher_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .smp_valid   (smp_valid),
    .cfg_involve (cfg_involve),
    .cfg_enable  (cfg_enable),
    .cfg_level   (cfg_level),
    .hit         (hit),
    .state_q     (state_q)
);

// File: tb/trig_matcher_tb.sv
module trig_matcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [15:0] cfg_involve = '0;
    logic [15:0] cfg_enable = '0;
    logic [15:0] cfg_level = '0;
    logic [15:0] cfg_polarity = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        hit;

    int checks = 0;
    int failures = 0;
    int dut_hits = 0;
    bit wd_expired = 1'b0;
    string cur_tag = "R1";
    string model_tag = "R1";

    // reference model state: 0 idle, 1 armed no history, 2 armed with history, 3 fired
    int          m_st = 0;
    logic [15:0] m_prev = '0;
    logic        exp_hit = 1'b0;

    always #4 clk = ~clk;

    trig_matcher u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .cfg_involve  (cfg_involve),
        .cfg_enable   (cfg_enable),
        .cfg_level    (cfg_level),
        .cfg_polarity (cfg_polarity),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .hit          (hit)
    );

    function automatic bit cond_met(input logic [15:0] d, input logic [15:0] p, input bit hp);
        bit ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (cfg_involve[i] && cfg_enable[i]) begin
                if (cfg_level[i]) begin
                    if (d[i] !== cfg_polarity[i]) ok = 1'b0;
                end else if (!hp) begin
                    ok = 1'b0;
                end else if (cfg_polarity[i]) begin
                    if (!(p[i] == 1'b1 && d[i] == 1'b0)) ok = 1'b0;
                end else begin
                    if (!(p[i] == 1'b0 && d[i] == 1'b1)) ok = 1'b0;
                end
            end
        end
        return ok;
    endfunction

    always @(posedge clk) begin
        model_tag = cur_tag;
        if (!rst_n) begin
            m_st = 0;
            exp_hit = 1'b0;
        end else begin
            exp_hit = 1'b0;
            if (!arm) begin
                m_st = 0;
            end else if (m_st == 0) begin
                m_st = 1;
            end else if ((m_st == 1 || m_st == 2) && smp_valid) begin
                if (cond_met(smp_data, m_prev, m_st == 2)) begin
                    exp_hit = 1'b1;
                    m_st = 3;
                end else begin
                    m_st = 2;
                end
                m_prev = smp_data;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (hit !== exp_hit) begin
            failures++;
            $display("FAIL %s cycle compare: hit actual=%0b expected=%0b", model_tag, hit, exp_hit);
        end
        if (hit === 1'b1) dut_hits++;
    end

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic cyc(input bit v, input logic [15:0] d);
        smp_valid = v;
        smp_data  = d;
        @(negedge clk);
        #1;
    endtask

    task automatic setup(input string tag, input logic [15:0] inv, input logic [15:0] en,
                         input logic [15:0] lvl, input logic [15:0] pol);
        arm = 1'b0;
        cyc(1'b0, '0);
        cur_tag = tag;
        cfg_involve = inv;
        cfg_enable = en;
        cfg_level = lvl;
        cfg_polarity = pol;
        dut_hits = 0;
        cyc(1'b0, '0);
        arm = 1'b1;
        cyc(1'b0, '0);
    endtask

    task automatic run_all();
        repeat (3) cyc(1'b0, '0);
        chk("R1 reset hit", int'(hit), 0);
        rst_n = 1'b1;
        cyc(1'b0, '0);
        chk("R1 idle after reset", int'(hit), 0);

        // R3: ch5 high level, ch9 low level
        setup("R3", 16'h0220, 16'h0220, 16'h0220, 16'h0020);
        cyc(1'b1, 16'h0000);
        cyc(1'b1, 16'h0220);
        chk("R3 partial levels", dut_hits, 0);
        cyc(1'b1, 16'h0020);
        cyc(1'b0, 16'h0000);
        chk("R3 level match", dut_hits, 1);

        // R4: ch2 rising, ch15 falling
        setup("R4", 16'h8004, 16'h8004, 16'h0000, 16'h8000);
        cyc(1'b1, 16'h8000);
        cyc(1'b1, 16'h8004);
        cyc(1'b1, 16'h0000);
        cyc(1'b1, 16'h8000);
        chk("R4 no joint edge yet", dut_hits, 0);
        cyc(1'b1, 16'h0004);
        cyc(1'b0, 16'h0000);
        chk("R4 rise plus fall", dut_hits, 1);

        // R5: ch0 high, ch1 low, ch3 rising
        setup("R5", 16'h000B, 16'h000B, 16'h0003, 16'h0001);
        cyc(1'b1, 16'h0003);
        cyc(1'b1, 16'h000B);
        cyc(1'b1, 16'h0001);
        chk("R5 not all channels", dut_hits, 0);
        cyc(1'b1, 16'h0009);
        cyc(1'b0, 16'h0000);
        chk("R5 all channels", dut_hits, 1);

        // R6: ch0 rising, first sample already high
        setup("R6", 16'h0001, 16'h0001, 16'h0000, 16'h0000);
        cyc(1'b1, 16'h0001);
        cyc(1'b1, 16'h0001);
        cyc(1'b0, 16'h0000);
        chk("R6 first sample no edge", dut_hits, 0);
        cyc(1'b1, 16'h0000);
        cyc(1'b1, 16'h0001);
        cyc(1'b0, 16'h0000);
        chk("R6 later edge", dut_hits, 1);

        // R7: nothing enabled
        setup("R7", 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF);
        cyc(1'b1, 16'h0000);
        cyc(1'b0, 16'h0000);
        chk("R7 empty condition", dut_hits, 1);

        // R2: enabled but not involved, and involved but not enabled
        setup("R2", 16'h0005, 16'h0003, 16'h0007, 16'h0007);
        cyc(1'b1, 16'h0001);
        cyc(1'b0, 16'h0000);
        chk("R2 only ch0 used", dut_hits, 1);

        // R9: invalid sample must not update history
        setup("R9", 16'h0001, 16'h0001, 16'h0000, 16'h0000);
        cyc(1'b1, 16'h0000);
        cyc(1'b0, 16'h0001);
        cyc(1'b0, 16'h0001);
        chk("R9 invalid ignored", dut_hits, 0);
        cyc(1'b1, 16'h0001);
        cyc(1'b0, 16'h0000);
        chk("R9 edge vs last valid", dut_hits, 1);

        // R8: single pulse per arming, then rearm
        setup("R8", 16'h0001, 16'h0001, 16'h0001, 16'h0001);
        for (int k = 0; k < 5; k++) cyc(1'b1, 16'h0001);
        chk("R8 one pulse", dut_hits, 1);
        arm = 1'b0;
        cyc(1'b1, 16'h0001);
        arm = 1'b1;
        cyc(1'b1, 16'h0001);
        chk("R10 arming edge not accepted", dut_hits, 1);
        cyc(1'b1, 16'h0001);
        cyc(1'b0, 16'h0000);
        chk("R8 rearm fires", dut_hits, 2);

        // R10: disarm cancels a matching sample
        setup("R10", 16'h0001, 16'h0001, 16'h0001, 16'h0001);
        arm = 1'b0;
        cyc(1'b1, 16'h0001);
        cyc(1'b1, 16'h0001);
        chk("R10 disarmed no hit", dut_hits, 0);
        arm = 1'b0;
        cyc(1'b0, 16'h0000);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_expired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_expired) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule